// File: doc/BRIEF.md
# Condition-Register Thread Synchronization Unit

This unit keeps the run state of a small, fixed set of hardware thread contexts that share one register file, together with a bank of one-bit condition registers that the threads use as binary semaphores. Decoded thread-control commands arrive from the pipeline at most one per cycle, each with a valid strobe. The unit needs no scheduler. A start command places a thread directly into its fixed slot. Halt and kill commands end a thread. Set, clear and wait commands operate on a condition register.

The unit reports which threads are running and which are blocked, and the value of every condition register. Toward the fetch stages it raises a one-cycle start event that carries the thread number and start address, and a one-cycle kill event that carries the thread number. A set releases at most one blocked waiter, the lowest-numbered thread waiting on that condition, and the set is consumed in doing so. If no thread is waiting, the condition stays set until a wait takes it or a clear drops it. Every state change is registered, so the result of a command shows on the outputs in the cycle after the command is accepted.

Opcodes on `cmd_op`: 0 no-op, 1 start, 2 halt, 3 kill, 4 set, 5 clear, 6 wait.

Top module: `tsu_top`

## Requirements
- R1: While reset is high and in the cycle after it, only thread 0 is running, no thread is blocked, every condition reads 0, and the start, kill and error outputs are low.
- R2: A start command (opcode 1) aimed at an inactive slot `cmd_tid` makes that thread running in the next cycle. In that cycle `start_valid` is high for exactly one cycle, with `start_tid` equal to `cmd_tid` and `start_addr` equal to `cmd_addr`.
- R3: A start command (opcode 1) aimed at a slot that is already active leaves every thread state unchanged. It pulses `start_err` for one cycle and does not raise `start_valid`.
- R4: A halt command (opcode 2) from the running thread `cmd_src` makes that thread inactive in the next cycle and pulses `kill_valid` with `kill_tid` equal to `cmd_src`.
- R5: A kill command (opcode 3) makes the active thread `cmd_tid` inactive in the next cycle and pulses `kill_valid` with `kill_tid` equal to `cmd_tid`. A blocked thread that is killed is also dropped from its wait list, so a later set on that condition finds no waiter.
- R6: A set command (opcode 4) on condition `cmd_cond` with no thread waiting on it makes that condition read 1 in the next cycle.
- R7: A set command (opcode 4) on a condition with one or more waiters releases exactly one of them, the lowest-numbered. The condition keeps reading 0.
- R8: A clear command (opcode 5) makes condition `cmd_cond` read 0 in the next cycle and releases no thread.
- R9: A wait command (opcode 6) from running thread `cmd_src` on a condition that reads 1 consumes the condition, which reads 0 in the next cycle. The thread stays running.
- R10: A wait command (opcode 6) from running thread `cmd_src` on a condition that reads 0 blocks that thread from the next cycle until a set on that condition or a kill releases it.
- R11: A cycle with `cmd_valid` low changes no thread or condition state and raises no start, kill or error pulse, whatever the other command inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_src | input | 2 | Thread that issued the command |
| cmd_tid | input | 2 | Target thread for start and kill |
| cmd_cond | input | 3 | Condition register index |
| cmd_addr | input | 32 | Start address for start |
| thr_running | output | 4 | Per-thread running flag |
| thr_blocked | output | 4 | Per-thread blocked-on-wait flag |
| cond_state | output | 8 | Condition register values |
| start_valid | output | 1 | One-cycle start event toward fetch |
| start_tid | output | 2 | Thread started |
| start_addr | output | 32 | Address at which the thread starts |
| kill_valid | output | 1 | One-cycle kill event toward fetch |
| kill_tid | output | 2 | Thread terminated |
| start_err | output | 1 | One-cycle flag: start aimed at an active slot |

## Verification
Several rules are checked on every cycle. At most one thread leaves the blocked state per cycle. A blocked thread is always an active one. A start event always names a thread that is then running. A start event and a start error never occur together. A clear drops its condition without waking anyone. A halt ends its issuer. An idle cycle changes nothing. Other behaviour depends on an ordered history, and only the bench scenarios can show it. These cases include which of two waiters a set picks, that a set with no waiter is kept until a later wait consumes it, that a second wait then blocks, and that a killed waiter no longer absorbs a set.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_START = 3'd1,
        OP_HALT  = 3'd2,
        OP_KILL  = 3'd3,
        OP_SET   = 3'd4,
        OP_CLR   = 3'd5,
        OP_WAIT  = 3'd6
    } tsu_op_e;

    typedef struct packed {
        logic do_start;
        logic do_halt;
        logic do_kill;
        logic do_set;
        logic do_clr;
        logic do_wait;
    } tsu_dec_t;

    function automatic tsu_dec_t tsu_decode(input logic valid, input tsu_op_e op);
        tsu_dec_t d;
        d          = '0;
        d.do_start = valid && (op == OP_START);
        d.do_halt  = valid && (op == OP_HALT);
        d.do_kill  = valid && (op == OP_KILL);
        d.do_set   = valid && (op == OP_SET);
        d.do_clr   = valid && (op == OP_CLR);
        d.do_wait  = valid && (op == OP_WAIT);
        return d;
    endfunction

endpackage

// File: rtl/tsu_cond_bank.sv
module tsu_cond_bank
    import tsu_pkg::*;
#(
    parameter int T  = 4,
    parameter int C  = 8,
    localparam int CW = $clog2(C)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tsu_dec_t             dec,
    input  logic [CW-1:0]        cond_idx,
    input  logic [T-1:0]         waiting,
    input  logic [T-1:0][CW-1:0] wait_cond,
    output logic [C-1:0]         cond_q,
    output logic                 cond_hit,
    output logic [T-1:0]         release_oh
);

    logic [T-1:0] match;

    // One comparator per thread against the addressed condition
    for (genvar t = 0; t < T; t++) begin : g_match
        assign match[t] = waiting[t] && (wait_cond[t] == cond_idx);
    end

    // Lowest-numbered waiter wins
    assign release_oh = dec.do_set ? (match & (~match + 1'b1)) : '0;
    assign cond_hit   = cond_q[cond_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
        end else if (dec.do_set && (match == '0)) begin
            cond_q[cond_idx] <= 1'b1;
        end else if (dec.do_clr) begin
            cond_q[cond_idx] <= 1'b0;
        end else if (dec.do_wait && cond_hit) begin
            cond_q[cond_idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/tsu_thread_table.sv
module tsu_thread_table
    import tsu_pkg::*;
#(
    parameter int T  = 4,
    parameter int C  = 8,
    localparam int TW = $clog2(T),
    localparam int CW = $clog2(C)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  tsu_dec_t             dec,
    input  logic [TW-1:0]        src,
    input  logic [TW-1:0]        tid,
    input  logic [CW-1:0]        cond_idx,
    input  logic                 cond_hit,
    input  logic [T-1:0]         release_oh,
    output logic [T-1:0]         act_q,
    output logic [T-1:0]         blk_q,
    output logic [T-1:0][CW-1:0] wc_q,
    output logic                 start_ok,
    output logic                 start_bad,
    output logic                 kill_fire,
    output logic [TW-1:0]        kill_id
);

    logic [T-1:0]         act_d;
    logic [T-1:0]         blk_d;
    logic [T-1:0][CW-1:0] wc_d;

    assign start_ok  = dec.do_start && !act_q[tid];
    assign start_bad = dec.do_start &&  act_q[tid];
    assign kill_fire = (dec.do_halt && act_q[src]) || (dec.do_kill && act_q[tid]);
    assign kill_id   = dec.do_halt ? src : tid;

    always_comb begin
        act_d = act_q;
        blk_d = blk_q;
        wc_d  = wc_q;
        if (start_ok) begin
            act_d[tid] = 1'b1;
            blk_d[tid] = 1'b0;
        end
        if (dec.do_halt) begin
            act_d[src] = 1'b0;
            blk_d[src] = 1'b0;
        end
        if (dec.do_kill) begin
            act_d[tid] = 1'b0;
            blk_d[tid] = 1'b0;
        end
        if (dec.do_set) begin
            blk_d = blk_d & ~release_oh;
        end
        if (dec.do_wait && !cond_hit) begin
            blk_d[src] = 1'b1;
            wc_d[src]  = cond_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= T'(1);
            blk_q <= '0;
            wc_q  <= '0;
        end else begin
            act_q <= act_d;
            blk_q <= blk_d;
            wc_q  <= wc_d;
        end
    end

endmodule

// File: rtl/tsu_fetch_events.sv
module tsu_fetch_events #(
    parameter int T  = 4,
    parameter int AW = 32,
    localparam int TW = $clog2(T)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_ok,
    input  logic          start_bad,
    input  logic [TW-1:0] tid,
    input  logic [AW-1:0] addr,
    input  logic          kill_fire,
    input  logic [TW-1:0] kill_id,
    output logic          start_valid,
    output logic [TW-1:0] start_tid,
    output logic [AW-1:0] start_addr,
    output logic          start_err,
    output logic          kill_valid,
    output logic [TW-1:0] kill_tid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_valid <= 1'b0;
            start_tid   <= '0;
            start_addr  <= '0;
            start_err   <= 1'b0;
            kill_valid  <= 1'b0;
            kill_tid    <= '0;
        end else begin
            start_valid <= start_ok;
            start_err   <= start_bad;
            kill_valid  <= kill_fire;
            if (start_ok) begin
                start_tid  <= tid;
                start_addr <= addr;
            end
            if (kill_fire) begin
                kill_tid <= kill_id;
            end
        end
    end

endmodule

// File: rtl/tsu_top.sv
module tsu_top
    import tsu_pkg::*;
#(
    parameter int T  = 4,
    parameter int C  = 8,
    parameter int AW = 32,
    localparam int TW = $clog2(T),
    localparam int CW = $clog2(C)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [TW-1:0] cmd_src,
    input  logic [TW-1:0] cmd_tid,
    input  logic [CW-1:0] cmd_cond,
    input  logic [AW-1:0] cmd_addr,
    output logic [T-1:0]  thr_running,
    output logic [T-1:0]  thr_blocked,
    output logic [C-1:0]  cond_state,
    output logic          start_valid,
    output logic [TW-1:0] start_tid,
    output logic [AW-1:0] start_addr,
    output logic          kill_valid,
    output logic [TW-1:0] kill_tid,
    output logic          start_err
);

    logic [T-1:0]         act_q;
    logic [T-1:0]         blk_q;
    logic [T-1:0][CW-1:0] wc_q;
    logic [T-1:0]         release_oh;
    logic                 cond_hit;
    logic                 start_ok;
    logic                 start_bad;
    logic                 kill_fire;
    logic [TW-1:0]        kill_id;
    tsu_dec_t             dec_raw;
    tsu_dec_t             dec;

    assign thr_running = act_q & ~blk_q;
    assign thr_blocked = blk_q;

    // Halt and wait only act when issued by a running thread
    always_comb begin
        dec_raw     = tsu_decode(cmd_valid, tsu_op_e'(cmd_op));
        dec         = dec_raw;
        dec.do_halt = dec_raw.do_halt && thr_running[cmd_src];
        dec.do_wait = dec_raw.do_wait && thr_running[cmd_src];
    end

    tsu_cond_bank #(.T(T), .C(C)) u_cond (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .cond_idx  (cmd_cond),
        .waiting   (blk_q),
        .wait_cond (wc_q),
        .cond_q    (cond_state),
        .cond_hit  (cond_hit),
        .release_oh(release_oh)
    );

    tsu_thread_table #(.T(T), .C(C)) u_thr (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .src       (cmd_src),
        .tid       (cmd_tid),
        .cond_idx  (cmd_cond),
        .cond_hit  (cond_hit),
        .release_oh(release_oh),
        .act_q     (act_q),
        .blk_q     (blk_q),
        .wc_q      (wc_q),
        .start_ok  (start_ok),
        .start_bad (start_bad),
        .kill_fire (kill_fire),
        .kill_id   (kill_id)
    );

    tsu_fetch_events #(.T(T), .AW(AW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start_ok   (start_ok),
        .start_bad  (start_bad),
        .tid        (cmd_tid),
        .addr       (cmd_addr),
        .kill_fire  (kill_fire),
        .kill_id    (kill_id),
        .start_valid(start_valid),
        .start_tid  (start_tid),
        .start_addr (start_addr),
        .start_err  (start_err),
        .kill_valid (kill_valid),
        .kill_tid   (kill_tid)
    );

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker
    import tsu_pkg::*;
#(
    parameter int T  = 4,
    parameter int C  = 8,
    localparam int TW = $clog2(T),
    localparam int CW = $clog2(C)
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [TW-1:0] cmd_src,
    input logic [CW-1:0] cmd_cond,
    input logic [T-1:0]  thr_running,
    input logic [T-1:0]  thr_blocked,
    input logic [C-1:0]  cond_state,
    input logic          start_valid,
    input logic [TW-1:0] start_tid,
    input logic          start_err,
    input logic          kill_valid,
    input logic [T-1:0]  act_q,
    input logic [T-1:0]  blk_q
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R7: a single cycle never frees more than one waiter
    p_single_release_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        $countones($past(thr_blocked) & ~thr_blocked) <= 1);

    // R10: only active threads can be blocked
    p_blocked_active_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        (blk_q & ~act_q) == '0);

    // R2: a start event names a thread that is running
    p_start_running_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        start_valid |-> thr_running[start_tid]);

    // R3: a start error never comes with a start event
    p_err_no_start_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        start_err |-> !start_valid);

    // R8: a clear zeroes its condition and wakes nobody
    p_clear_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (cmd_valid && cmd_op == OP_CLR) |=>
            (!cond_state[$past(cmd_cond)] && (($past(thr_blocked) & ~thr_blocked) == '0)));

    // R4: halt from a running thread ends it
    p_halt_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        (cmd_valid && cmd_op == OP_HALT && thr_running[cmd_src]) |=>
            (!thr_running[$past(cmd_src)] && !thr_blocked[$past(cmd_src)] && kill_valid));

    // R11: an idle cycle changes nothing
    p_idle_r11: assert property (@(posedge clk) disable iff (rst || !armed)
        !cmd_valid |=> ($stable(thr_running) && $stable(thr_blocked) && $stable(cond_state)
                        && !start_valid && !kill_valid && !start_err));

endmodule

bind tsu_top tsu_checker #(.T(T), .C(C)) chk_i (.*);

// File: tb/tsu_top_tb_top.sv
module tsu_top_tb_top;

    localparam int CLK_P = 10;
    localparam int NV    = 20;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  src;
        logic [1:0]  tid;
        logic [2:0]  cnd;
        logic [15:0] addr;
        logic [3:0]  run;
        logic [3:0]  blk;
        logic [7:0]  cst;
        logic        sv;
        logic        kv;
        logic        err;
    } vec_t;

    // op src tid cnd addr run blk cst sv kv err
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd0, 2'd1, 3'd0, 16'h0100, 4'b0011, 4'b0000, 8'h00, 1'b1, 1'b0, 1'b0}, // R2
        '{3'd1, 2'd0, 2'd2, 3'd0, 16'h0200, 4'b0111, 4'b0000, 8'h00, 1'b1, 1'b0, 1'b0}, // R2
        '{3'd6, 2'd1, 2'd0, 3'd3, 16'h0000, 4'b0101, 4'b0010, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
        '{3'd6, 2'd2, 2'd0, 3'd3, 16'h0000, 4'b0001, 4'b0110, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
        '{3'd4, 2'd0, 2'd0, 3'd3, 16'h0000, 4'b0011, 4'b0100, 8'h00, 1'b0, 1'b0, 1'b0}, // R7
        '{3'd4, 2'd0, 2'd0, 3'd3, 16'h0000, 4'b0111, 4'b0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R7
        '{3'd4, 2'd0, 2'd0, 3'd5, 16'h0000, 4'b0111, 4'b0000, 8'h20, 1'b0, 1'b0, 1'b0}, // R6
        '{3'd6, 2'd1, 2'd0, 3'd5, 16'h0000, 4'b0111, 4'b0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R9
        '{3'd4, 2'd0, 2'd0, 3'd6, 16'h0000, 4'b0111, 4'b0000, 8'h40, 1'b0, 1'b0, 1'b0}, // R6
        '{3'd5, 2'd0, 2'd0, 3'd6, 16'h0000, 4'b0111, 4'b0000, 8'h00, 1'b0, 1'b0, 1'b0}, // R8
        '{3'd1, 2'd0, 2'd1, 3'd0, 16'h0300, 4'b0111, 4'b0000, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        '{3'd6, 2'd2, 2'd0, 3'd1, 16'h0000, 4'b0011, 4'b0100, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
        '{3'd5, 2'd0, 2'd0, 3'd1, 16'h0000, 4'b0011, 4'b0100, 8'h00, 1'b0, 1'b0, 1'b0}, // R8
        '{3'd3, 2'd0, 2'd2, 3'd0, 16'h0000, 4'b0011, 4'b0000, 8'h00, 1'b0, 1'b1, 1'b0}, // R5
        '{3'd4, 2'd0, 2'd0, 3'd1, 16'h0000, 4'b0011, 4'b0000, 8'h02, 1'b0, 1'b0, 1'b0}, // R5
        '{3'd2, 2'd1, 2'd0, 3'd0, 16'h0000, 4'b0001, 4'b0000, 8'h02, 1'b0, 1'b1, 1'b0}, // R4
        '{3'd4, 2'd0, 2'd0, 3'd4, 16'h0000, 4'b0001, 4'b0000, 8'h12, 1'b0, 1'b0, 1'b0}, // R6
        '{3'd6, 2'd0, 2'd0, 3'd4, 16'h0000, 4'b0001, 4'b0000, 8'h02, 1'b0, 1'b0, 1'b0}, // R9
        '{3'd6, 2'd0, 2'd0, 3'd4, 16'h0000, 4'b0000, 4'b0001, 8'h02, 1'b0, 1'b0, 1'b0}, // R10
        '{3'd4, 2'd0, 2'd0, 3'd4, 16'h0000, 4'b0001, 4'b0000, 8'h02, 1'b0, 1'b0, 1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_src = '0;
    logic [1:0]  cmd_tid = '0;
    logic [2:0]  cmd_cond = '0;
    logic [31:0] cmd_addr = '0;
    logic [3:0]  thr_running;
    logic [3:0]  thr_blocked;
    logic [7:0]  cond_state;
    logic        start_valid;
    logic [1:0]  start_tid;
    logic [31:0] start_addr;
    logic        kill_valid;
    logic [1:0]  kill_tid;
    logic        start_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tsu_top dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_tid(cmd_tid), .cmd_cond(cmd_cond), .cmd_addr(cmd_addr),
        .thr_running(thr_running), .thr_blocked(thr_blocked), .cond_state(cond_state),
        .start_valid(start_valid), .start_tid(start_tid), .start_addr(start_addr),
        .kill_valid(kill_valid), .kill_tid(kill_tid), .start_err(start_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op, input logic err);
        case (op)
            3'd1:    return err ? "R3" : "R2";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6/R7";
            3'd5:    return "R8";
            default: return "R9/R10";
        endcase
    endfunction

    task automatic issue(input logic v, input logic [2:0] op, input logic [1:0] src,
                         input logic [1:0] tid, input logic [2:0] cnd, input logic [31:0] addr);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cmd_src   = src;
        cmd_tid   = tid;
        cmd_cond  = cnd;
        cmd_addr  = addr;
        @(posedge clk);
        #1;
    endtask

    task automatic check_reset_state();
        check(thr_running == 4'b0001, "R1", "running", 32'(thr_running), 32'h1);
        check(thr_blocked == 4'b0000, "R1", "blocked", 32'(thr_blocked), 32'h0);
        check(cond_state == 8'h00, "R1", "conditions", 32'(cond_state), 32'h0);
        check({start_valid, kill_valid, start_err} == 3'b000, "R1", "pulses",
              32'({start_valid, kill_valid, start_err}), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state(); // R1 during reset
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_reset_state(); // R1 after reset

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string r;
            v = VECS[i];
            r = req_of(v.op, v.err);
            issue(1'b1, v.op, v.src, v.tid, v.cnd, 32'(v.addr));
            check(thr_running == v.run, r, $sformatf("row %0d running", i), 32'(thr_running), 32'(v.run));
            check(thr_blocked == v.blk, r, $sformatf("row %0d blocked", i), 32'(thr_blocked), 32'(v.blk));
            check(cond_state == v.cst, r, $sformatf("row %0d conditions", i), 32'(cond_state), 32'(v.cst));
            check({start_valid, kill_valid, start_err} == {v.sv, v.kv, v.err}, r,
                  $sformatf("row %0d pulses", i),
                  32'({start_valid, kill_valid, start_err}), 32'({v.sv, v.kv, v.err}));
            if (v.sv) begin
                check(start_tid == v.tid, r, $sformatf("row %0d start_tid", i), 32'(start_tid), 32'(v.tid));
                check(start_addr == 32'(v.addr), r, $sformatf("row %0d start_addr", i), start_addr, 32'(v.addr));
            end
            if (v.kv) begin
                logic [1:0] k;
                k = (v.op == 3'd2) ? v.src : v.tid;
                check(kill_tid == k, r, $sformatf("row %0d kill_tid", i), 32'(kill_tid), 32'(k));
            end
        end

        // R11: strobe low with a start pattern on the other inputs
        issue(1'b0, 3'd1, 2'd0, 2'd3, 3'd2, 32'h0000_0400);
        check(thr_running == 4'b0001, "R11", "running after idle", 32'(thr_running), 32'h1);
        check(start_valid == 1'b0, "R11", "start pulse on idle", 32'(start_valid), 32'h0);
        // R11: strobe low with a set pattern
        issue(1'b0, 3'd4, 2'd0, 2'd0, 3'd7, 32'h0);
        check(cond_state == 8'h02, "R11", "conditions after idle", 32'(cond_state), 32'h02);

        // R2: start pulse lasts one cycle
        issue(1'b1, 3'd1, 2'd0, 2'd3, 3'd0, 32'hCAFE_0010);
        check(start_valid && start_tid == 2'd3 && start_addr == 32'hCAFE_0010, "R2",
              "start event thread 3", start_addr, 32'hCAFE_0010);
        issue(1'b0, 3'd0, 2'd0, 2'd0, 3'd0, 32'h0);
        check(start_valid == 1'b0, "R2", "start pulse width", 32'(start_valid), 32'h0);
        check(thr_running == 4'b1001, "R2", "running after start", 32'(thr_running), 32'h9);

        // R1: reset in mid-run restores the initial state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check_reset_state();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule